// File: doc/BRIEF.md
# Save/Restore Controller Status and Lock Register Bank

This block is the register bank of a save/restore controller that manages sixteen descriptor groups. It holds five event status flags raised by the execution engine, a field that records which descriptor caused the most recent address or bus fault, a global control word, and one control word per group. Each group control word carries an enable bit, an owner domain field, and three lock bits.

Software reaches the bank through a simple request/response register port. Every request carries the domain ID of the requester. A group's locks decide whether an access to that group's word may proceed. The domain lock admits only the owner. The write lock refuses every write and the read lock refuses every read. A refused access returns zero data with an error response and changes nothing. Lock bits can be set by software but cannot be cleared by it. Only the hardware reset clears them.

A soft-reset bit in the global word returns the controller registers to their idle values and leaves the locks and owners in place. The descriptor memory sits elsewhere and is not touched.

Top module: `sr_ctl_regs`

## Requirements
- R1: After hardware reset all flags, the error index, the hardware-request disable, and every group's enable, owner and lock bits are zero, and no response is pending.
- R2: Event inputs set status flags at bit positions: 0 address error, 1 bus error, 2 software-request done, 3 timeout, 4 group conflict. The status word at byte address 0x04 reads flags in bits [4:0].
- R3: A write to 0x04 clears each flag among bits 0, 1, 3 and 4 whose written bit is 1. Bit 2 (done) is unaffected by such writes.
- R4: When an event and a write-one-to-clear hit the same flag in the same cycle, the flag is set afterwards.
- R5: An address-error or bus-error event loads the error index from the event's index input. The status word shows it in bits [25:16].
- R6: The group word for group g is at byte address 0x40+4*g. Its fields are bit 0 enable, bit 1 domain lock, bit 2 write lock, bit 3 read lock, and bits [7:4] owner domain. Writing a lock bit as 0 never clears it. The owner field is frozen while the domain lock is set.
- R7: While a group's domain lock is set, an access from any other domain returns error with zero data, and a write is dropped.
- R8: While a group's write lock is set, every write to that word returns error and is dropped.
- R9: While a group's read lock is set, every read of that word returns error with zero data. Writes are still accepted.
- R10: Writing 1 to bit 0 of the global word at 0x00 clears the flags, the error index, the hardware-request disable and all group enables. Locks and owners are kept. The soft reset also wins over a same-cycle event.
- R11: Bit 1 of the global word is the hardware-request disable. It reads back and drives its output. Bit 0 reads as 0.
- R12: Every request produces a response exactly one cycle later. An address outside the mapped words returns error with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_domain | input | 4 | Requester domain ID |
| resp_valid | output | 1 | Response strobe, one cycle after request |
| resp_err | output | 1 | Access refused or unmapped |
| resp_rdata | output | 32 | Read data, zero on error |
| ev_flags | input | 5 | Event pulses, one per status flag |
| ev_index | input | 10 | Descriptor index sent with fault events |
| flags_o | output | 5 | Current status flags |
| err_index_o | output | 10 | Recorded fault descriptor index |
| hw_req_dis_o | output | 1 | Disables power-controller requests |
| grp_en_o | output | 16 | Group enables |
| grp_dlock_o | output | 16 | Group domain locks |
| grp_wlock_o | output | 16 | Group write locks |
| grp_rlock_o | output | 16 | Group read locks |

## Verification
An engine event and a software write-one-to-clear can arrive for the same flag in one clock. The bench provokes this by driving a timeout event pulse and a status write with bit 3 set on the same falling edge. It then requires the timeout flag to remain set, while other flags cleared by the same write do go low. The soft reset is also raced against an event, and there the flags must all read zero.

// File: rtl/sr_regs_pkg.sv
package sr_regs_pkg;
    localparam int FLG_N    = 5;
    localparam int FLG_ADDR = 0;
    localparam int FLG_BUS  = 1;
    localparam int FLG_DONE = 2;
    localparam int FLG_TMO  = 3;
    localparam int FLG_CONF = 4;
    localparam logic [FLG_N-1:0] W1C_MASK = 5'b11011;

    localparam int GB_EN      = 0;
    localparam int GB_DLOCK   = 1;
    localparam int GB_WLOCK   = 2;
    localparam int GB_RLOCK   = 3;
    localparam int GB_OWN_LSB = 4;

    localparam int GC_SRST  = 0;
    localparam int GC_HWDIS = 1;
    localparam int IDX_LSB  = 16;
endpackage

// File: rtl/sr_status_flags.sv
module sr_status_flags
    import sr_regs_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             w1c_en,
    input  logic [FLG_N-1:0] w1c_mask,
    input  logic [FLG_N-1:0] ev_flags,
    input  logic [IDX_W-1:0] ev_index,
    output logic [FLG_N-1:0] flags_o,
    output logic [IDX_W-1:0] index_o
);
    typedef struct packed {
        logic [FLG_N-1:0] flags;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (w1c_en)
            st_d.flags = st_d.flags & ~(w1c_mask & W1C_MASK);
        st_d.flags = st_d.flags | ev_flags;
        if (ev_flags[FLG_ADDR] || ev_flags[FLG_BUS])
            st_d.idx = ev_index;
        if (soft_clr)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign index_o = st_q.idx;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_flags) && !soft_clr) |=> ((flags_o & $past(ev_flags)) == $past(ev_flags))); // R4
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLG_DONE] && !soft_clr) |=> flags_o[FLG_DONE]); // R3
    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_flags[FLG_ADDR] || ev_flags[FLG_BUS]) && !soft_clr) |=> (index_o == $past(ev_index))); // R5
    AST_SOFT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (flags_o == '0 && index_o == '0)); // R10
endmodule

// File: rtl/sr_group_ctl.sv
module sr_group_ctl
    import sr_regs_pkg::*;
#(
    parameter int DOM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic [GB_OWN_LSB+DOM_W-1:0] wdata,
    output logic             en_o,
    output logic             dlock_o,
    output logic             wlock_o,
    output logic             rlock_o,
    output logic [DOM_W-1:0] owner_o
);
    typedef struct packed {
        logic             en;
        logic             dlock;
        logic             wlock;
        logic             rlock;
        logic [DOM_W-1:0] owner;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_en) begin
            g_d.en    = wdata[GB_EN];
            g_d.dlock = g_q.dlock | wdata[GB_DLOCK];
            g_d.wlock = g_q.wlock | wdata[GB_WLOCK];
            g_d.rlock = g_q.rlock | wdata[GB_RLOCK];
            if (!g_q.dlock)
                g_d.owner = wdata[GB_OWN_LSB +: DOM_W];
        end
        if (soft_clr)
            g_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign en_o    = g_q.en;
    assign dlock_o = g_q.dlock;
    assign wlock_o = g_q.wlock;
    assign rlock_o = g_q.rlock;
    assign owner_o = g_q.owner;

    AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dlock_o || wlock_o || rlock_o) |=>
        ((dlock_o >= $past(dlock_o)) && (wlock_o >= $past(wlock_o)) && (rlock_o >= $past(rlock_o)))); // R6
    AST_WLOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (wlock_o && !soft_clr) |=> ($stable(en_o) && $stable(owner_o))); // R8
    AST_OWNER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        dlock_o |=> $stable(owner_o)); // R7
endmodule

// File: rtl/sr_ctl_regs.sv
module sr_ctl_regs
    import sr_regs_pkg::*;
#(
    parameter int NGRP     = 16,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DOM_W    = 4,
    parameter int IDX_W    = 10,
    parameter int GRP_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DOM_W-1:0]  req_domain,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic [FLG_N-1:0]  ev_flags,
    input  logic [IDX_W-1:0]  ev_index,
    output logic [FLG_N-1:0]  flags_o,
    output logic [IDX_W-1:0]  err_index_o,
    output logic              hw_req_dis_o,
    output logic [NGRP-1:0]   grp_en_o,
    output logic [NGRP-1:0]   grp_dlock_o,
    output logic [NGRP-1:0]   grp_wlock_o,
    output logic [NGRP-1:0]   grp_rlock_o
);
    localparam int GI_W     = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int GW_W     = GB_OWN_LSB + DOM_W;
    localparam int GRP_END  = GRP_BASE + 4 * NGRP;
    localparam logic [ADDR_W-1:0] A_GCTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(4);

    typedef struct packed {
        logic              rvalid;
        logic              rerr;
        logic [DATA_W-1:0] rdata;
        logic              hwdis;
    } top_t;

    top_t t_d, t_q;

    logic [DOM_W-1:0] g_own [NGRP];
    logic [NGRP-1:0]  g_wr;
    logic             soft_clr, w1c_en;

    logic              hit_gc, hit_st, hit_grp, blocked;
    logic [ADDR_W-1:0] off;
    logic [GI_W-1:0]   gidx;
    logic [DATA_W-1:0] rd;

    always_comb begin
        off     = req_addr - ADDR_W'(GRP_BASE);
        gidx    = off[2 +: GI_W];
        hit_gc  = (req_addr == A_GCTRL);
        hit_st  = (req_addr == A_STATUS);
        hit_grp = (int'(req_addr) >= GRP_BASE) && (int'(req_addr) < GRP_END) && (req_addr[1:0] == 2'b00);
        blocked = 1'b0;
        if (hit_grp) begin
            if (grp_dlock_o[gidx] && (req_domain != g_own[gidx])) blocked = 1'b1;
            if (req_write && grp_wlock_o[gidx])                   blocked = 1'b1;
            if (!req_write && grp_rlock_o[gidx])                  blocked = 1'b1;
        end

        soft_clr = req_valid && req_write && hit_gc && req_wdata[GC_SRST];
        w1c_en   = req_valid && req_write && hit_st;
        g_wr     = '0;
        if (req_valid && req_write && hit_grp && !blocked)
            g_wr[gidx] = 1'b1;

        rd = '0;
        if (hit_gc) begin
            rd[GC_HWDIS] = t_q.hwdis;
        end else if (hit_st) begin
            rd[FLG_N-1:0]           = flags_o;
            rd[IDX_LSB +: IDX_W]    = err_index_o;
        end else if (hit_grp) begin
            rd[GB_EN]               = grp_en_o[gidx];
            rd[GB_DLOCK]            = grp_dlock_o[gidx];
            rd[GB_WLOCK]            = grp_wlock_o[gidx];
            rd[GB_RLOCK]            = grp_rlock_o[gidx];
            rd[GB_OWN_LSB +: DOM_W] = g_own[gidx];
        end

        t_d        = t_q;
        t_d.rvalid = req_valid;
        t_d.rerr   = 1'b0;
        t_d.rdata  = '0;
        if (req_valid) begin
            if (!(hit_gc || hit_st || hit_grp) || blocked)
                t_d.rerr = 1'b1;
            else if (!req_write)
                t_d.rdata = rd;
            if (req_write && hit_gc)
                t_d.hwdis = req_wdata[GC_HWDIS];
        end
        if (soft_clr)
            t_d.hwdis = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign resp_valid   = t_q.rvalid;
    assign resp_err     = t_q.rerr;
    assign resp_rdata   = t_q.rdata;
    assign hw_req_dis_o = t_q.hwdis;

    sr_status_flags #(.IDX_W(IDX_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .w1c_en   (w1c_en),
        .w1c_mask (req_wdata[FLG_N-1:0]),
        .ev_flags (ev_flags),
        .ev_index (ev_index),
        .flags_o  (flags_o),
        .index_o  (err_index_o)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        sr_group_ctl #(.DOM_W(DOM_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .wr_en    (g_wr[g]),
            .wdata    (req_wdata[GW_W-1:0]),
            .en_o     (grp_en_o[g]),
            .dlock_o  (grp_dlock_o[g]),
            .wlock_o  (grp_wlock_o[g]),
            .rlock_o  (grp_rlock_o[g]),
            .owner_o  (g_own[g])
        );
    end

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_rdata == '0)); // R7
    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R12
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R12
    AST_HWDIS_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!hw_req_dis_o && grp_en_o == '0)); // R10
endmodule

// File: tb/tb_sr_ctl_regs.sv
module tb_sr_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_domain = '0;
    logic        resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic [4:0]  ev_flags = '0;
    logic [9:0]  ev_index = '0;
    logic [4:0]  flags_o;
    logic [9:0]  err_index_o;
    logic        hw_req_dis_o;
    logic [15:0] grp_en_o, grp_dlock_o, grp_wlock_o, grp_rlock_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sr_ctl_regs dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_domain(req_domain),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .ev_flags(ev_flags), .ev_index(ev_index),
        .flags_o(flags_o), .err_index_o(err_index_o), .hw_req_dis_o(hw_req_dis_o),
        .grp_en_o(grp_en_o), .grp_dlock_o(grp_dlock_o),
        .grp_wlock_o(grp_wlock_o), .grp_rlock_o(grp_rlock_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  dom;
        logic        err;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h04, 32'h0,  4'd0, 1'b0, 32'h0},   // R1 status zero
        '{1'b1, 8'h40, 32'h51, 4'd0, 1'b0, 32'h0},   // R6 en + owner 5
        '{1'b0, 8'h40, 32'h0,  4'd3, 1'b0, 32'h51},  // R6 readback
        '{1'b1, 8'h40, 32'h53, 4'd0, 1'b0, 32'h0},   // R6 set domain lock
        '{1'b0, 8'h40, 32'h0,  4'd3, 1'b1, 32'h0},   // R7 foreign read
        '{1'b1, 8'h40, 32'h0,  4'd3, 1'b1, 32'h0},   // R7 foreign write
        '{1'b0, 8'h40, 32'h0,  4'd5, 1'b0, 32'h53},  // R7 write dropped
        '{1'b1, 8'h40, 32'h0,  4'd5, 1'b0, 32'h0},   // R6 try clearing lock
        '{1'b0, 8'h40, 32'h0,  4'd5, 1'b0, 32'h52},  // R6 lock sticky, owner kept
        '{1'b1, 8'h44, 32'h5,  4'd0, 1'b0, 32'h0},   // R8 set write lock
        '{1'b1, 8'h44, 32'h0,  4'd0, 1'b1, 32'h0},   // R8 write refused
        '{1'b0, 8'h44, 32'h0,  4'd0, 1'b0, 32'h5},   // R8 unchanged
        '{1'b1, 8'h48, 32'h9,  4'd0, 1'b0, 32'h0},   // R9 set read lock
        '{1'b0, 8'h48, 32'h0,  4'd0, 1'b1, 32'h0},   // R9 read refused
        '{1'b1, 8'h48, 32'h0,  4'd0, 1'b0, 32'h0},   // R9 write still taken
        '{1'b1, 8'h00, 32'h2,  4'd0, 1'b0, 32'h0},   // R11 set hw disable
        '{1'b0, 8'h00, 32'h0,  4'd0, 1'b0, 32'h2},   // R11 readback
        '{1'b0, 8'h20, 32'h0,  4'd0, 1'b1, 32'h0},   // R12 unmapped
        '{1'b1, 8'h7C, 32'h1,  4'd0, 1'b0, 32'h0}    // R6 last group
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] dom, output logic err, output logic [31:0] rdata);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_domain = dom;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (resp_valid !== 1'b1) begin
            errors++;
            $display("FAIL R12: actual resp_valid %b expected 1", resp_valid);
        end
        err = resp_err; rdata = resp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [3:0] dom,
                          input logic [31:0] exp);
        logic e; logic [31:0] r;
        access(1'b0, a, 32'h0, dom, e, r);
        chk(req, {31'b0, e}, 32'h0);
        chk(req, r, exp);
    endtask

    task automatic wr_op(input logic [7:0] a, input logic [31:0] d);
        logic e; logic [31:0] r;
        access(1'b1, a, d, 4'd0, e, r);
    endtask

    task automatic pulse_ev(input logic [4:0] f, input logic [9:0] idx);
        @(negedge clk);
        ev_flags = f; ev_index = idx;
        @(negedge clk);
        ev_flags = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic e; logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk("R1", {27'b0, flags_o}, 32'h0);
        chk("R1", {22'b0, err_index_o}, 32'h0);
        chk("R1", {grp_en_o, grp_dlock_o}, 32'h0);
        chk("R1", {grp_wlock_o, grp_rlock_o}, 32'h0);
        chk("R1", {31'b0, resp_valid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].wr, TBL[i].addr, TBL[i].wdata, TBL[i].dom, e, r);
            chk("table err", {31'b0, e}, {31'b0, TBL[i].err});
            if (!TBL[i].wr) chk("table rdata", r, TBL[i].rdata);
        end
        chk("R11", {31'b0, hw_req_dis_o}, 32'h1);
        rd_chk("R6", 8'h7C, 4'd0, 32'h1);

        // R2 R5 address-error event with index
        pulse_ev(5'b00001, 10'h2A5);
        chk("R2", {27'b0, flags_o}, 32'h1);
        chk("R5", {22'b0, err_index_o}, 32'h2A5);
        rd_chk("R5", 8'h04, 4'd0, 32'h02A5_0001);
        // R2 all flags
        pulse_ev(5'b11110, 10'h013);
        rd_chk("R2", 8'h04, 4'd0, 32'h0013_001F);
        // R3 clear everything: done stays
        wr_op(8'h04, 32'h1F);
        chk("R3", {27'b0, flags_o}, 32'h04);
        // R4 timeout event and clear of timeout+conflict in same cycle
        pulse_ev(5'b11000, 10'h013);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h18; req_domain = '0;
        ev_flags = 5'b01000;
        @(negedge clk);
        req_valid = 1'b0; ev_flags = '0;
        chk("R4", {27'b0, flags_o}, 32'h0C);

        // R10 soft reset raced with an event
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'h3; req_domain = '0;
        ev_flags = 5'b00010; ev_index = 10'h3FF;
        @(negedge clk);
        req_valid = 1'b0; ev_flags = '0;
        chk("R10", {27'b0, flags_o}, 32'h0);
        chk("R10", {22'b0, err_index_o}, 32'h0);
        chk("R10", {31'b0, hw_req_dis_o}, 32'h0);
        chk("R10", {16'b0, grp_en_o}, 32'h0);
        chk("R10", {16'b0, grp_wlock_o}, 32'h2);
        chk("R10", {16'b0, grp_rlock_o}, 32'h4);
        rd_chk("R10", 8'h40, 4'd5, 32'h52);
        rd_chk("R10", 8'h44, 4'd0, 32'h4);
        rd_chk("R11", 8'h00, 4'd0, 32'h0);
        // R7 owner match after soft reset still admitted, foreign refused
        access(1'b0, 8'h40, 32'h0, 4'd1, e, r);
        chk("R7", {31'b0, e}, 32'h1);
        chk("R7", r, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule